// File: doc/BRIEF.md
# Memory-Management Fault Capture Registers

This block holds the details of the most recent memory-management fault so that a fault handler can read them. On the data side, a capture request carries the faulting virtual address, a 6-bit fault flag field, the faulting instruction's 6-bit opcode and 5-bit register number, and a page-table base value. The block stores three values from that request:

- the address itself;
- a packed status word built from the opcode, register number and flags;
- the address of the page-table entry that maps the faulting page.

After a capture the data-side registers are held. Later faults cannot overwrite them until software reads the captured address through a read strobe.

The instruction side keeps two values: the faulting program counter and a page-table-entry address built from its own base value. It is never held, so every accepted instruction fault overwrites it. On both sides, a request marked as speculative is dropped, because work on a mispredicted path must not disturb the handler's state.

Top module: `fault_capture_regs`

## Requirements
- R1: While reset is active, every output register reads zero and the data side is unlocked.
- R2: A data fault request that is not speculative, arriving while the data side is unlocked, loads the address into `d_va_o` at the next clock edge and locks the data side.
- R3: On a capture, `d_stat_o` is packed as follows: opcode in bits 16:11, register number in bits 10:6, fault flags in bits 5:0.
- R4: On a capture, `d_form_o` equals the base value ORed with (address >> PAGE_SHIFT) << 3, truncated to VA_W bits. PAGE_SHIFT defaults to 13.
- R5: While the data side is locked and no read strobe is present, a data fault request leaves all three data outputs unchanged.
- R6: A data fault request with `d_spec_i` high changes no data output and does not change the lock.
- R7: A read strobe `va_rd_i` with no accepted fault in the same cycle unlocks the data side at that clock edge, so the next fault request is captured.
- R8: A non-speculative data fault in the same cycle as the read strobe is captured, and the data side stays locked.
- R9: Every non-speculative instruction fault loads `i_pc_o` and `i_form_o`, where `i_form_o` = base | (pc >> PAGE_SHIFT) << 3. The data-side lock has no effect on this capture.
- R10: An instruction fault request with `i_spec_i` high leaves `i_pc_o` and `i_form_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_fault_i | input | 1 | Data-side fault capture request |
| d_spec_i | input | 1 | Data-side request is speculative |
| d_va_i | input | VA_W | Faulting data virtual address |
| d_flags_i | input | 6 | Fault flag field |
| d_opcode_i | input | 6 | Faulting instruction opcode |
| d_reg_i | input | 5 | Faulting instruction register number |
| d_ptbase_i | input | VA_W | Data-side page-table base value |
| va_rd_i | input | 1 | Read strobe of the captured data address |
| i_fault_i | input | 1 | Instruction-side fault capture request |
| i_spec_i | input | 1 | Instruction-side request is speculative |
| i_pc_i | input | VA_W | Faulting program counter |
| i_ptbase_i | input | VA_W | Instruction-side page-table base value |
| d_va_o | output | VA_W | Captured data address |
| d_stat_o | output | 17 | Packed fault status |
| d_form_o | output | VA_W | Data-side page-table-entry address |
| i_pc_o | output | VA_W | Captured program counter |
| i_form_o | output | VA_W | Instruction-side page-table-entry address |

## Verification
The lock is internal state. A wrong lock value shows at the ports one clock after the next data fault request, in one of two ways:

- a stuck-set lock leaves `d_va_o` unchanged when a fault should have been captured;
- a stuck-clear lock lets a second fault overwrite the first.

The bench therefore follows every lock transition with a fault request, including a request in the same cycle as the read strobe. A wrong packing or shift shows in the same cycle as the capture, so capture patterns use distinct values in every field and an address with its top bits set.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;
    localparam int FLAG_W = 6;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int STAT_W = OPC_W + REG_W + FLAG_W;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic [OPC_W-1:0]  opc,
        input logic [REG_W-1:0]  rnum,
        input logic [FLAG_W-1:0] flags
    );
        return {opc, rnum, flags};
    endfunction
endpackage

// File: rtl/fault_pte_form.sv
module fault_pte_form #(
    parameter int VA_W       = 48,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic [VA_W-1:0] va_i,
    input  logic [VA_W-1:0] base_i,
    output logic [VA_W-1:0] form_o
);
    logic [VA_W-1:0] vpn;

    always_comb begin
        vpn    = va_i >> PAGE_SHIFT;
        form_o = base_i | (vpn << PTE_SHIFT);
    end
endmodule

// File: rtl/fault_dside.sv
module fault_dside
    import fault_capture_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int PAGE_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_i,
    input  logic              spec_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [VA_W-1:0]   ptbase_i,
    input  logic              rd_i,
    output logic [VA_W-1:0]   va_o,
    output logic [STAT_W-1:0] stat_o,
    output logic [VA_W-1:0]   form_o,
    output logic              lock_o
);
    typedef struct packed {
        logic [VA_W-1:0]   va;
        logic [STAT_W-1:0] stat;
        logic [VA_W-1:0]   form;
        logic              lock;
    } dstate_t;

    dstate_t         s_d, s_q;
    logic [VA_W-1:0] form_w;
    logic            accept;

    fault_pte_form #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_form (
        .va_i   (va_i),
        .base_i (ptbase_i),
        .form_o (form_w)
    );

    always_comb begin
        s_d    = s_q;
        accept = fault_i && !spec_i && (!s_q.lock || rd_i);
        if (accept) begin
            s_d.va   = va_i;
            s_d.stat = pack_status(opcode_i, reg_i, flags_i);
            s_d.form = form_w;
            s_d.lock = 1'b1;
        end else if (rd_i) begin
            s_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign va_o   = s_q.va;
    assign stat_o = s_q.stat;
    assign form_o = s_q.form;
    assign lock_o = s_q.lock;
endmodule

// File: rtl/fault_iside.sv
module fault_iside #(
    parameter int VA_W       = 48,
    parameter int PAGE_SHIFT = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_i,
    input  logic            spec_i,
    input  logic [VA_W-1:0] pc_i,
    input  logic [VA_W-1:0] ptbase_i,
    output logic [VA_W-1:0] pc_o,
    output logic [VA_W-1:0] form_o
);
    typedef struct packed {
        logic [VA_W-1:0] pc;
        logic [VA_W-1:0] form;
    } istate_t;

    istate_t         s_d, s_q;
    logic [VA_W-1:0] form_w;

    fault_pte_form #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_form (
        .va_i   (pc_i),
        .base_i (ptbase_i),
        .form_o (form_w)
    );

    always_comb begin
        s_d = s_q;
        if (fault_i && !spec_i) begin
            s_d.pc   = pc_i;
            s_d.form = form_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_o   = s_q.pc;
    assign form_o = s_q.form;
endmodule

// File: rtl/fault_capture_regs.sv
module fault_capture_regs #(
    parameter int VA_W       = 48,
    parameter int PAGE_SHIFT = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            d_fault_i,
    input  logic            d_spec_i,
    input  logic [VA_W-1:0] d_va_i,
    input  logic [5:0]      d_flags_i,
    input  logic [5:0]      d_opcode_i,
    input  logic [4:0]      d_reg_i,
    input  logic [VA_W-1:0] d_ptbase_i,
    input  logic            va_rd_i,
    input  logic            i_fault_i,
    input  logic            i_spec_i,
    input  logic [VA_W-1:0] i_pc_i,
    input  logic [VA_W-1:0] i_ptbase_i,
    output logic [VA_W-1:0] d_va_o,
    output logic [16:0]     d_stat_o,
    output logic [VA_W-1:0] d_form_o,
    output logic [VA_W-1:0] i_pc_o,
    output logic [VA_W-1:0] i_form_o
);
    logic d_lock;

    fault_dside #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_dside (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (d_fault_i),
        .spec_i   (d_spec_i),
        .va_i     (d_va_i),
        .flags_i  (d_flags_i),
        .opcode_i (d_opcode_i),
        .reg_i    (d_reg_i),
        .ptbase_i (d_ptbase_i),
        .rd_i     (va_rd_i),
        .va_o     (d_va_o),
        .stat_o   (d_stat_o),
        .form_o   (d_form_o),
        .lock_o   (d_lock)
    );

    fault_iside #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_iside (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (i_fault_i),
        .spec_i   (i_spec_i),
        .pc_i     (i_pc_i),
        .ptbase_i (i_ptbase_i),
        .pc_o     (i_pc_o),
        .form_o   (i_form_o)
    );
endmodule

// File: rtl/fault_capture_regs_chk.sv
module fault_capture_regs_chk #(
    parameter int VA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            d_fault_i,
    input logic            d_spec_i,
    input logic [VA_W-1:0] d_va_i,
    input logic [5:0]      d_opcode_i,
    input logic            va_rd_i,
    input logic            i_fault_i,
    input logic            i_spec_i,
    input logic [VA_W-1:0] i_pc_i,
    input logic [VA_W-1:0] d_va_o,
    input logic [16:0]     d_stat_o,
    input logic [VA_W-1:0] i_pc_o,
    input logic            d_lock
);
    // R2
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (d_fault_i && !d_spec_i && !d_lock) |=> (d_lock && d_va_o == $past(d_va_i)));
    // R3
    a_r3_opcode_field: assert property (@(posedge clk) disable iff (!rst_n)
        (d_fault_i && !d_spec_i && (!d_lock || va_rd_i)) |=> (d_stat_o[16:11] == $past(d_opcode_i)));
    // R5
    a_r5_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (d_lock && !va_rd_i) |=> ($stable(d_va_o) && $stable(d_stat_o) && d_lock));
    // R6
    a_r6_spec_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (d_spec_i && !va_rd_i) |=> ($stable(d_va_o) && $stable(d_lock)));
    // R7
    a_r7_read_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (va_rd_i && !(d_fault_i && !d_spec_i)) |=> !d_lock);
    // R8
    a_r8_read_and_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (va_rd_i && d_fault_i && !d_spec_i) |=> (d_lock && d_va_o == $past(d_va_i)));
    // R9
    a_r9_iside_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (i_fault_i && !i_spec_i) |=> (i_pc_o == $past(i_pc_i)));
    // R10
    a_r10_iside_spec: assert property (@(posedge clk) disable iff (!rst_n)
        (!(i_fault_i && !i_spec_i)) |=> $stable(i_pc_o));
endmodule

bind fault_capture_regs fault_capture_regs_chk #(.VA_W(VA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_fault_i  (d_fault_i),
    .d_spec_i   (d_spec_i),
    .d_va_i     (d_va_i),
    .d_opcode_i (d_opcode_i),
    .va_rd_i    (va_rd_i),
    .i_fault_i  (i_fault_i),
    .i_spec_i   (i_spec_i),
    .i_pc_i     (i_pc_i),
    .d_va_o     (d_va_o),
    .d_stat_o   (d_stat_o),
    .i_pc_o     (i_pc_o),
    .d_lock     (d_lock)
);

// File: tb/fault_capture_regs_bench.sv
`timescale 1ns/1ps
module fault_capture_regs_bench;
    localparam int VA_W = 48;
    localparam int PS   = 13;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            d_fault_i = 0, d_spec_i = 0, va_rd_i = 0;
    logic [VA_W-1:0] d_va_i = '0, d_ptbase_i = '0;
    logic [5:0]      d_flags_i = '0, d_opcode_i = '0;
    logic [4:0]      d_reg_i = '0;
    logic            i_fault_i = 0, i_spec_i = 0;
    logic [VA_W-1:0] i_pc_i = '0, i_ptbase_i = '0;
    logic [VA_W-1:0] d_va_o, d_form_o, i_pc_o, i_form_o;
    logic [16:0]     d_stat_o;

    fault_capture_regs #(.VA_W(VA_W), .PAGE_SHIFT(PS)) u_fault_capture_regs (
        .clk(clk), .rst_n(rst_n),
        .d_fault_i(d_fault_i), .d_spec_i(d_spec_i), .d_va_i(d_va_i),
        .d_flags_i(d_flags_i), .d_opcode_i(d_opcode_i), .d_reg_i(d_reg_i),
        .d_ptbase_i(d_ptbase_i), .va_rd_i(va_rd_i),
        .i_fault_i(i_fault_i), .i_spec_i(i_spec_i), .i_pc_i(i_pc_i),
        .i_ptbase_i(i_ptbase_i),
        .d_va_o(d_va_o), .d_stat_o(d_stat_o), .d_form_o(d_form_o),
        .i_pc_o(i_pc_o), .i_form_o(i_form_o)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    logic [VA_W-1:0] m_va, m_form, m_pc, m_iform;
    logic [16:0]     m_stat;
    bit              m_held;
    int              checks = 0, fails = 0, cycles = 0;
    string           phase = "R1 reset";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_va = '0; m_form = '0; m_pc = '0; m_iform = '0; m_stat = '0; m_held = 0;
        end else begin
            if (d_fault_i && !d_spec_i && (!m_held || va_rd_i)) begin
                m_va   = d_va_i;
                m_stat = 17'((int'(d_opcode_i) << 11) + (int'(d_reg_i) << 6) + int'(d_flags_i));
                m_form = d_ptbase_i | ((d_va_i >> PS) << 3);
                m_held = 1;
            end else if (va_rd_i) begin
                m_held = 0;
            end
            if (i_fault_i && !i_spec_i) begin
                m_pc    = i_pc_i;
                m_iform = i_ptbase_i | ((i_pc_i >> PS) << 3);
            end
        end
    end

    task automatic cmp(input string what, input logic [VA_W-1:0] act, input logic [VA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        cmp("d_va_o", d_va_o, m_va);
        cmp("d_stat_o", VA_W'(d_stat_o), VA_W'(m_stat));
        cmp("d_form_o", d_form_o, m_form);
        cmp("i_pc_o", i_pc_o, m_pc);
        cmp("i_form_o", i_form_o, m_iform);
        if (cycles > 5000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic dfault(input logic [VA_W-1:0] va, input logic [5:0] op,
                          input logic [4:0] rn, input logic [5:0] fl,
                          input logic [VA_W-1:0] base, input logic spec, input logic rd);
        d_fault_i = 1; d_spec_i = spec; va_rd_i = rd;
        d_va_i = va; d_opcode_i = op; d_reg_i = rn; d_flags_i = fl; d_ptbase_i = base;
        @(negedge clk);
        d_fault_i = 0; d_spec_i = 0; va_rd_i = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        phase = "R1 reset";
        idle(3);
        rst_n = 1;
        idle(1);
        cmp("R1 zero va", d_va_o, '0);
        cmp("R1 zero form", i_form_o, '0);

        phase = "R2 R3 R4 first capture";
        dfault(48'hFFFF_8000_6000, 6'h2A, 5'h15, 6'h33, 48'h0000_4000_0000, 0, 0);
        cmp("R2 va", d_va_o, 48'hFFFF_8000_6000);
        cmp("R3 stat", VA_W'(d_stat_o), VA_W'({6'h2A, 5'h15, 6'h33}));
        cmp("R4 form", d_form_o, 48'h0000_4000_0000 | ((48'hFFFF_8000_6000 >> 13) << 3));

        phase = "R5 locked";
        dfault(48'h1234_5678_9ABC, 6'h01, 5'h02, 6'h03, 48'h10, 0, 0);
        dfault(48'h0000_0000_2000, 6'h11, 5'h1F, 6'h3F, 48'h20, 0, 0);
        cmp("R5 va kept", d_va_o, 48'hFFFF_8000_6000);

        phase = "R7 read unlocks";
        va_rd_i = 1; idle(1); va_rd_i = 0;
        phase = "R6 speculative";
        dfault(48'hAAAA_BBBB_C000, 6'h05, 5'h06, 6'h07, 48'h0, 1, 0);
        cmp("R6 va kept", d_va_o, 48'hFFFF_8000_6000);
        phase = "R7 capture after read";
        dfault(48'h0000_0ABC_D000, 6'h3F, 5'h00, 6'h01, 48'hF000, 0, 0);
        cmp("R7 va", d_va_o, 48'h0000_0ABC_D000);

        phase = "R8 read with fault";
        dfault(48'h7777_0000_E000, 6'h12, 5'h0A, 6'h2C, 48'h8, 0, 1);
        cmp("R8 va", d_va_o, 48'h7777_0000_E000);
        dfault(48'h0101_0101_0101, 6'h00, 5'h00, 6'h00, 48'h0, 0, 0);
        cmp("R8 relocked", d_va_o, 48'h7777_0000_E000);

        phase = "R9 iside";
        i_fault_i = 1; i_spec_i = 0; i_ptbase_i = 48'h0000_0100_0000;
        i_pc_i = 48'h0000_1234_0004; idle(1);
        i_pc_i = 48'hFFFF_FFFF_E008; idle(1);
        i_fault_i = 0;
        cmp("R9 pc", i_pc_o, 48'hFFFF_FFFF_E008);
        phase = "R10 iside spec";
        i_fault_i = 1; i_spec_i = 1; i_pc_i = 48'h5555_5555_5554; idle(1);
        i_fault_i = 0; i_spec_i = 0;
        cmp("R10 pc kept", i_pc_o, 48'hFFFF_FFFF_E008);

        phase = "mixed";
        for (int k = 0; k < 40; k++) begin
            d_fault_i = k[0]; d_spec_i = (k % 5 == 0); va_rd_i = (k % 7 == 3);
            d_va_i = VA_W'(k * 48'h0000_0123_4567_1);
            d_opcode_i = 6'(k); d_reg_i = 5'(k * 3); d_flags_i = 6'(k * 5);
            i_fault_i = k[1]; i_spec_i = (k % 3 == 0); i_pc_i = VA_W'(k * 48'h0000_0987_6543);
            idle(1);
        end
        d_fault_i = 0; va_rd_i = 0; i_fault_i = 0;
        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule